// File: doc/BRIEF.md
# Bandwidth-Limited Squash Walker

When a misspeculation resolves, the reorder buffer must invalidate every in-flight entry of the affected thread that is younger than the branch or faulting instruction. This block does that work one thread at a time, per thread, without removing anything from the buffer. A request names a thread and a boundary sequence number. The thread's walker then starts at that thread's youngest entry and moves toward older entries over as many cycles as needed. In each cycle it handles at most `SQ_WIDTH` entries. Each entry whose sequence number is strictly above the boundary receives a mark strobe. The entry storage reacts to that strobe by setting both the entry's squashed flag and its ready-to-commit flag. Marked entries then leave through ordinary retirement.

The entry storage stays outside the block. Each thread owns a circular region of `DEPTH` slots. The storage presents every slot's sequence number, each thread's oldest slot index and each thread's entry count. The block returns a per-slot mark vector, a busy and a done bit per thread, and a single-cycle request to recompute the global tail whenever a thread's youngest entry is marked. Allocation logic should stall a thread while its busy bit is high.

Each thread has its own controller with two states, `SQ_IDLE` and `SQ_WALK`. There are three named transitions:
- ACCEPT (`SQ_IDLE` to `SQ_WALK`): a request arrives for a thread that holds entries.
- RESTART (`SQ_WALK` to `SQ_WALK`): a new request arrives for a thread that is already walking. The pointer and boundary reload.
- COMPLETE (`SQ_WALK` to `SQ_IDLE`): the step in progress reaches the boundary or the thread's oldest entry.

When no request is taken and the walk does not complete, the controller stays in `SQ_WALK`. Sequence numbers are compared as plain unsigned values.

Top module: `rob_squash_walker`

## Requirements
- R1: After reset, every busy bit is 0, every done bit is 1, the mark vector is all zero and the tail-recompute output is 0.
- R2: A request is ignored when the named thread holds no entries, which includes the case of an empty buffer. In the following cycle busy stays 0 and done stays 1 for every thread.
- R3: An accepted request raises that thread's busy bit and clears its done bit from the next cycle on. The first walk step happens in that next cycle and starts at the youngest slot, (oldest + count − 1) mod DEPTH.
- R4: In each walk cycle a thread marks at most SQ_WIDTH slots. The marked slots are consecutive, run from the pointer toward older slots (index decreasing, wrapping from 0 to DEPTH−1), and each has a sequence number strictly greater than the boundary, compared as unsigned values.
- R5: If the slot under the pointer has a sequence number at or below the boundary when a step begins, the walk completes in that cycle and marks nothing.
- R6: When a step marks the thread's oldest slot, the walk completes in that same cycle, and the oldest slot is included in that cycle's marks.
- R7: After a step's batch, if the slot now under the pointer has a sequence number at or below the boundary, the walk completes in that cycle. Busy is 0 and done is 1 from the next cycle.
- R8: The tail-recompute output is high in exactly those cycles in which some thread marks the youngest slot its current walk started from.
- R9: A request for a thread that is already walking restarts the walk from the thread's current youngest slot with the new boundary. That thread marks nothing in the cycle the request is taken, and busy stays high.
- R10: Threads walk independently and concurrently, each under its own SQ_WIDTH limit. A request for one thread does not affect another thread's walk.
- R11: A thread's busy bit is high exactly while it is in `SQ_WALK`, and its busy and done bits are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sq_valid_i | input | 1 | Squash request strobe |
| sq_tid_i | input | TID_W | Thread named by the request |
| sq_bound_i | input | SEQ_W | Boundary sequence number; entries strictly above it are squashed |
| seq_flat_i | input | THREADS*DEPTH*SEQ_W | Sequence number of every slot; thread t slot e at bits (t*DEPTH+e)*SEQ_W upward |
| oldest_flat_i | input | THREADS*IDX_W | Oldest slot index of each thread, thread t at bits t*IDX_W upward |
| count_flat_i | input | THREADS*CNT_W | Entry count of each thread, thread t at bits t*CNT_W upward |
| mark_o | output | THREADS*DEPTH | Bit t*DEPTH+e high: set squashed and ready-to-commit on thread t slot e at this edge |
| busy_o | output | THREADS | Per-thread walk in progress |
| done_o | output | THREADS | Per-thread squash finished (1 when idle) |
| tail_recompute_o | output | 1 | Pulse: a youngest entry was squashed this cycle, recompute the global tail |

## Verification
The assertions assume that a thread's sequence numbers, oldest index and count stay constant while its walk runs. That holds because allocation is stalled by busy, and retirement is not expected to advance a walking thread's head. They also assume that a request names a thread below THREADS. The stimulus changes buffer contents only at falling edges while every thread is idle, and it only names existing threads. The one exception is the restart case, where the contents are deliberately left unchanged while a second request arrives.

// File: rtl/rob_sq_pkg.sv
package rob_sq_pkg;

    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_WALK = 1'b1
    } sq_state_e;

endpackage

// File: rtl/rob_sq_batch.sv
module rob_sq_batch #(
    parameter int DEPTH    = 8,
    parameter int SEQ_W    = 8,
    parameter int SQ_WIDTH = 2,
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input  logic             en_i,
    input  logic [SEQ_W-1:0] seq_i [DEPTH],
    input  logic [IDX_W-1:0] ptr_i,
    input  logic [IDX_W-1:0] oldest_i,
    input  logic [SEQ_W-1:0] bound_i,
    output logic [DEPTH-1:0] mark_o,
    output logic [IDX_W-1:0] ptr_o,
    output logic             finish_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    // One cycle of the walk: SQ_WIDTH chained lanes, each handling one slot.
    always_comb begin
        logic [IDX_W-1:0] cur;
        logic             alive;
        logic             hit_oldest;
        cur        = ptr_i;
        alive      = en_i;
        hit_oldest = 1'b0;
        mark_o     = '0;
        for (int lane = 0; lane < SQ_WIDTH; lane++) begin
            if (alive && (seq_i[cur] > bound_i)) begin
                mark_o[cur] = 1'b1;
                if (cur == oldest_i) begin
                    hit_oldest = 1'b1;
                    alive      = 1'b0;
                end else if (cur == '0) begin
                    cur = LAST_IDX;
                end else begin
                    cur = cur - 1'b1;
                end
            end else begin
                alive = 1'b0;
            end
        end
        ptr_o    = cur;
        finish_o = en_i && (hit_oldest || (seq_i[cur] <= bound_i));
    end

endmodule

// File: rtl/rob_sq_thread.sv
module rob_sq_thread
    import rob_sq_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int SEQ_W    = 8,
    parameter int SQ_WIDTH = 2,
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [SEQ_W-1:0] bound_i,
    input  logic [SEQ_W-1:0] seq_i [DEPTH],
    input  logic [IDX_W-1:0] oldest_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [DEPTH-1:0] mark_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             tail_hit_o
);

    sq_state_e        state_q, state_d;
    logic [IDX_W-1:0] ptr_q, young_q, youngest_c, step_ptr;
    logic [SEQ_W-1:0] bound_q;
    logic             done_q;
    logic             accept, step_en, step_finish;
    logic [DEPTH-1:0] step_mark;

    assign accept = req_i && (count_i != '0);

    // Youngest slot = (oldest + count - 1) mod DEPTH
    always_comb begin
        int s;
        s = int'(oldest_i) + int'(count_i) - 1;
        if (s >= DEPTH) s = s - DEPTH;
        if (s < 0) s = 0;
        youngest_c = IDX_W'(s);
    end

    assign step_en = (state_q == SQ_WALK) && !accept;

    rob_sq_batch #(
        .DEPTH   (DEPTH),
        .SEQ_W   (SEQ_W),
        .SQ_WIDTH(SQ_WIDTH)
    ) batch_i (
        .en_i    (step_en),
        .seq_i   (seq_i),
        .ptr_i   (ptr_q),
        .oldest_i(oldest_i),
        .bound_i (bound_q),
        .mark_o  (step_mark),
        .ptr_o   (step_ptr),
        .finish_o(step_finish)
    );

    // Next-state: ACCEPT, RESTART, COMPLETE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: if (accept) state_d = SQ_WALK;
            SQ_WALK: begin
                if (accept)           state_d = SQ_WALK;
                else if (step_finish) state_d = SQ_IDLE;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // Walk datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            young_q <= '0;
            bound_q <= '0;
            done_q  <= 1'b1;
        end else if (accept) begin
            ptr_q   <= youngest_c;
            young_q <= youngest_c;
            bound_q <= bound_i;
            done_q  <= 1'b0;
        end else if (step_en) begin
            ptr_q <= step_ptr;
            if (step_finish) done_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            SQ_IDLE: begin
                busy_o = 1'b0;
                mark_o = '0;
            end
            SQ_WALK: begin
                busy_o = 1'b1;
                mark_o = step_mark;
            end
            default: begin
                busy_o = 1'b0;
                mark_o = '0;
            end
        endcase
        done_o     = done_q;
        tail_hit_o = mark_o[young_q];
    end

    p_busy_not_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o);
    p_width_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mark_o) <= SQ_WIDTH);
    p_mark_needs_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|mark_o) |-> busy_o);
    p_complete_sets_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
    p_ignore_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && count_i == '0 && !busy_o) |=> !busy_o);
    p_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && count_i != '0) |=> (busy_o && !done_o));
    p_restart_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && busy_o) |-> (mark_o == '0));
    p_tail_needs_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tail_hit_o |-> busy_o);

    for (genvar e = 0; e < DEPTH; e++) begin : g_chk
        p_mark_younger_r4: assert property (@(posedge clk) disable iff (!rst_n)
            mark_o[e] |-> (seq_i[e] > bound_q));
    end

endmodule

// File: rtl/rob_squash_walker.sv
module rob_squash_walker #(
    parameter int THREADS  = 2,
    parameter int DEPTH    = 8,
    parameter int SEQ_W    = 8,
    parameter int SQ_WIDTH = 2,
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int TID_W   = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sq_valid_i,
    input  logic [TID_W-1:0]               sq_tid_i,
    input  logic [SEQ_W-1:0]               sq_bound_i,
    input  logic [THREADS*DEPTH*SEQ_W-1:0] seq_flat_i,
    input  logic [THREADS*IDX_W-1:0]       oldest_flat_i,
    input  logic [THREADS*CNT_W-1:0]       count_flat_i,
    output logic [THREADS*DEPTH-1:0]       mark_o,
    output logic [THREADS-1:0]             busy_o,
    output logic [THREADS-1:0]             done_o,
    output logic                           tail_recompute_o
);

    logic [THREADS-1:0] tail_vec;

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        logic [SEQ_W-1:0] seq_arr [DEPTH];
        logic             req;

        for (genvar e = 0; e < DEPTH; e++) begin : g_unpack
            assign seq_arr[e] = seq_flat_i[(t*DEPTH+e)*SEQ_W +: SEQ_W];
        end

        assign req = sq_valid_i && (sq_tid_i == TID_W'(t));

        rob_sq_thread #(
            .DEPTH   (DEPTH),
            .SEQ_W   (SEQ_W),
            .SQ_WIDTH(SQ_WIDTH)
        ) thr_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_i     (req),
            .bound_i   (sq_bound_i),
            .seq_i     (seq_arr),
            .oldest_i  (oldest_flat_i[t*IDX_W +: IDX_W]),
            .count_i   (count_flat_i[t*CNT_W +: CNT_W]),
            .mark_o    (mark_o[t*DEPTH +: DEPTH]),
            .busy_o    (busy_o[t]),
            .done_o    (done_o[t]),
            .tail_hit_o(tail_vec[t])
        );
    end

    assign tail_recompute_o = |tail_vec;

    p_tail_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tail_recompute_o |-> (|mark_o));

endmodule

// File: tb/rob_squash_walker_tb.sv
module rob_squash_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sq_valid = 1'b0;
    logic [0:0]  sq_tid = '0;
    logic [7:0]  sq_bound = '0;
    logic [127:0] seq_flat;
    logic [5:0]  oldest_flat;
    logic [7:0]  count_flat;
    logic [15:0] mark;
    logic [1:0]  busy, done;
    logic        tail;

    logic [7:0] seq_m [2][8];
    logic [2:0] old_m [2];
    logic [3:0] cnt_m [2];

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int t = 0; t < 2; t++) begin
            for (int e = 0; e < 8; e++) seq_flat[(t*8+e)*8 +: 8] = seq_m[t][e];
            oldest_flat[t*3 +: 3] = old_m[t];
            count_flat[t*4 +: 4]  = cnt_m[t];
        end
    end

    rob_squash_walker dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .sq_valid_i      (sq_valid),
        .sq_tid_i        (sq_tid),
        .sq_bound_i      (sq_bound),
        .seq_flat_i      (seq_flat),
        .oldest_flat_i   (oldest_flat),
        .count_flat_i    (count_flat),
        .mark_o          (mark),
        .busy_o          (busy),
        .done_o          (done),
        .tail_recompute_o(tail)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_cyc(input string req, input logic [15:0] m, input logic [1:0] b,
                           input logic [1:0] d, input logic tl);
        chk(req, "mark", 32'(mark), 32'(m));
        chk(req, "busy", 32'(busy), 32'(b));
        chk(req, "done", 32'(done), 32'(d));
        chk(req, "tail", 32'(tail), 32'(tl));
    endtask

    task automatic clear_buf();
        for (int t = 0; t < 2; t++) begin
            for (int e = 0; e < 8; e++) seq_m[t][e] = 8'h00;
            old_m[t] = 3'd0;
            cnt_m[t] = 4'd0;
        end
    endtask

    task automatic request(input logic [0:0] tid, input logic [7:0] bnd);
        sq_tid   = tid;
        sq_bound = bnd;
        sq_valid = 1'b1;
    endtask

    // R3 R4 R7 R8: plain multi-cycle walk stopping at the boundary
    task automatic t_basic();
        @(negedge clk);
        clear_buf();
        old_m[0] = 3'd2; cnt_m[0] = 4'd6;
        for (int e = 2; e < 8; e++) seq_m[0][e] = 8'(8 + e);
        request(1'b0, 8'd11);
        @(negedge clk); sq_valid = 1'b0; #1;
        chk_cyc("R3", 16'h00C0, 2'b01, 2'b10, 1'b1);
        @(negedge clk); #1;
        chk_cyc("R4", 16'h0030, 2'b01, 2'b10, 1'b0);
        @(negedge clk); #1;
        chk_cyc("R7", 16'h0000, 2'b00, 2'b11, 1'b0);
    endtask

    // R6: wrap-around walk ending at the oldest slot
    task automatic t_oldest();
        @(negedge clk);
        clear_buf();
        old_m[1] = 3'd6; cnt_m[1] = 4'd3;
        seq_m[1][6] = 8'd20; seq_m[1][7] = 8'd21; seq_m[1][0] = 8'd22;
        request(1'b1, 8'd5);
        @(negedge clk); sq_valid = 1'b0; #1;
        chk_cyc("R4", 16'h8100, 2'b10, 2'b01, 1'b1);
        @(negedge clk); #1;
        chk_cyc("R6", 16'h4000, 2'b10, 2'b01, 1'b0);
        @(negedge clk); #1;
        chk_cyc("R6", 16'h0000, 2'b00, 2'b11, 1'b0);
    endtask

    // R5: youngest already at the boundary
    task automatic t_nothing();
        @(negedge clk);
        clear_buf();
        cnt_m[0] = 4'd3;
        seq_m[0][0] = 8'd1; seq_m[0][1] = 8'd2; seq_m[0][2] = 8'd3;
        request(1'b0, 8'd3);
        @(negedge clk); sq_valid = 1'b0; #1;
        chk_cyc("R5", 16'h0000, 2'b01, 2'b10, 1'b0);
        @(negedge clk); #1;
        chk_cyc("R5", 16'h0000, 2'b00, 2'b11, 1'b0);
    endtask

    // R2: empty buffer, then empty thread while the other holds entries
    task automatic t_empty();
        @(negedge clk);
        clear_buf();
        request(1'b0, 8'd0);
        @(negedge clk); sq_valid = 1'b0; #1;
        chk_cyc("R2", 16'h0000, 2'b00, 2'b11, 1'b0);
        cnt_m[0] = 4'd2; seq_m[0][0] = 8'd9; seq_m[0][1] = 8'd10;
        request(1'b1, 8'd0);
        @(negedge clk); sq_valid = 1'b0; #1;
        chk_cyc("R2", 16'h0000, 2'b00, 2'b11, 1'b0);
    endtask

    // R9: restart while walking
    task automatic t_restart();
        @(negedge clk);
        clear_buf();
        cnt_m[0] = 4'd8;
        for (int e = 0; e < 8; e++) seq_m[0][e] = 8'(100 + e);
        request(1'b0, 8'd100);
        @(negedge clk); sq_valid = 1'b0; #1;
        chk_cyc("R9", 16'h00C0, 2'b01, 2'b10, 1'b1);
        @(negedge clk); request(1'b0, 8'd105); #1;
        chk_cyc("R9", 16'h0000, 2'b01, 2'b10, 1'b0);
        @(negedge clk); sq_valid = 1'b0; #1;
        chk_cyc("R9", 16'h00C0, 2'b01, 2'b10, 1'b1);
        @(negedge clk); #1;
        chk_cyc("R11", 16'h0000, 2'b00, 2'b11, 1'b0);
    endtask

    // R10: two threads walking at once
    task automatic t_concurrent();
        @(negedge clk);
        clear_buf();
        cnt_m[0] = 4'd4;
        for (int e = 0; e < 4; e++) seq_m[0][e] = 8'(50 + e);
        cnt_m[1] = 4'd5;
        for (int e = 0; e < 5; e++) seq_m[1][e] = 8'(60 + e);
        request(1'b0, 8'd49);
        @(negedge clk); request(1'b1, 8'd61); #1;
        chk_cyc("R10", 16'h000C, 2'b01, 2'b10, 1'b1);
        @(negedge clk); sq_valid = 1'b0; #1;
        chk_cyc("R10", 16'h1803, 2'b11, 2'b00, 1'b1);
        @(negedge clk); #1;
        chk_cyc("R10", 16'h0400, 2'b10, 2'b01, 1'b0);
        @(negedge clk); #1;
        chk_cyc("R10", 16'h0000, 2'b00, 2'b11, 1'b0);
    endtask

    // R4: unsigned comparison near the top of the range
    task automatic t_unsigned();
        @(negedge clk);
        clear_buf();
        cnt_m[0] = 4'd4;
        seq_m[0][0] = 8'h7F; seq_m[0][1] = 8'h80; seq_m[0][2] = 8'hFE; seq_m[0][3] = 8'hFF;
        request(1'b0, 8'h80);
        @(negedge clk); sq_valid = 1'b0; #1;
        chk_cyc("R4", 16'h000C, 2'b01, 2'b10, 1'b1);
        @(negedge clk); #1;
        chk_cyc("R7", 16'h0000, 2'b00, 2'b11, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        clear_buf();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk_cyc("R1", 16'h0000, 2'b00, 2'b11, 1'b0);
        t_basic();
        t_oldest();
        t_nothing();
        t_empty();
        t_restart();
        t_concurrent();
        t_unsigned();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule